// File: doc/BRIEF.md
# Shift-Sequence Receive Pattern Checker

This block watches the sample stream of each receive channel of a data converter while the converter's built-in self-test generator is running. In the self-test mode used here, every new 12-bit word is the previous word rotated by one bit position. The checker predicts each word from the one before it and records any departure from that rule.

There is one independent checker lane per channel. Each lane keeps two sticky flags: a mismatch flag, and an out-of-sync flag that marks a mismatch seen before the lane ever locked. Software runs a simple loop on these flags. It reads the status word and writes the same value back to clear the flags that were set. It then reads again, and a working link returns zero. A small register port gives access to the flags, with one status word per channel.

Top module: `shift_pattern_checker`

## Requirements
- R1: With a valid word present and the lane armed, the word is compared with the previous valid word of that channel rotated left by one bit (new bit i+1 = old bit i, new bit 0 = old bit 11). An equal word raises no flag, including across the wrap from 0x800 to 0x001.
- R2: A word that differs from the prediction sets the mismatch flag, status bit 1. The register read shows it in the cycle after the word is presented, and not in the cycle the word is presented.
- R3: The first valid word after reset, or after any write to that channel's status register, only seeds the predictor and never sets a flag.
- R4: A mismatch seen while the lane has had no matching word since reset or since its last register write also sets the out-of-sync flag, status bit 2, so the status reads 6. A mismatch after a match reads 2.
- R5: Writing a status register clears each flag whose bit in the write data is 1 and leaves the flags whose bit is 0. Writing back the value just read clears it to 0. With no such write, a set flag stays set.
- R6: When a mismatch and a clear of the same flag fall in the same cycle, the flag ends up set.
- R7: Address 0 selects channel 0 and address 1 selects channel 1. Traffic on one channel and writes to one channel's register leave the other channel's status unchanged.
- R8: After reset, both status words read 0. Status bits other than 1 and 2 always read 0.
- R9: Cycles with the channel's valid low are ignored. They do not move the predictor and do not change the flags, whatever the data lines carry.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ch_valid | input | NUM_CH | Per-channel word strobe |
| ch_data | input | NUM_CH*DATA_W | Channel words, channel n in bits [n*DATA_W +: DATA_W] |
| reg_wr | input | 1 | Status register write strobe (write-1-to-clear) |
| reg_addr | input | ADDR_W | Channel select for read and write |
| reg_wdata | input | REG_W | Write data, clear mask |
| reg_rdata | output | REG_W | Status of the addressed channel, combinational |

## Verification
On every cycle the assertions check these rules: a mismatch raises its flag in the next cycle, a mismatch before lock also raises the out-of-sync flag, and a seeding word never raises a flag. They also check that a set beats a simultaneous clear, that a clear without a set takes effect, that idle cycles leave the flags untouched, and that at most one lane is written at a time. Other behaviours can only be shown by the bench's scenarios. These are the exact rotate direction and its wrap, the status values 6 and 2 as software sees them, the write-back loop, and the isolation between channels.

// File: rtl/psc_pkg.sv
package psc_pkg;

    typedef enum logic {
        ROT_LEFT  = 1'b0,
        ROT_RIGHT = 1'b1
    } rot_dir_e;

    localparam int MISS_BIT = 1;
    localparam int OOS_BIT  = 2;

    typedef struct packed {
        logic oos;
        logic miss;
    } lane_flags_t;

    typedef struct packed {
        logic clr_oos;
        logic clr_miss;
    } lane_clr_t;

endpackage

// File: rtl/psc_predictor.sv
module psc_predictor
    import psc_pkg::*;
#(
    parameter int       DATA_W  = 12,
    parameter rot_dir_e ROT_DIR = ROT_LEFT
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              valid,
    input  logic [DATA_W-1:0] data,
    input  logic              restart,
    output logic [DATA_W-1:0] expect_word,
    output logic              armed
);

    logic [DATA_W-1:0] prev_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            prev_q <= '0;
            armed  <= 1'b0;
        end else begin
            if (valid) prev_q <= data;
            if (restart)    armed <= 1'b0;
            else if (valid) armed <= 1'b1;
        end
    end

    generate
        if (ROT_DIR == ROT_LEFT) begin : g_rotl
            assign expect_word = {prev_q[DATA_W-2:0], prev_q[DATA_W-1]};
        end else begin : g_rotr
            assign expect_word = {prev_q[0], prev_q[DATA_W-1:1]};
        end
    endgenerate

    // R3: a register write forces the next valid word to reseed
    assert_restart_disarms_R3: assert property (@(posedge clk) disable iff (rst)
        restart |=> !armed);

    // R9: idle cycles keep the predictor state
    assert_idle_holds_pred_R9: assert property (@(posedge clk) disable iff (rst)
        (!valid && !restart) |=> ($stable(prev_q) && $stable(armed)));

endmodule

// File: rtl/psc_lane.sv
module psc_lane
    import psc_pkg::*;
#(
    parameter int       DATA_W  = 12,
    parameter rot_dir_e ROT_DIR = ROT_LEFT
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              valid,
    input  logic [DATA_W-1:0] data,
    input  logic              wr_sel,
    input  lane_clr_t         clr,
    output lane_flags_t       flags
);

    logic [DATA_W-1:0] expect_word;
    logic              armed;
    logic              locked_q;
    logic              compare_en;
    logic              hit;
    logic              miss;

    psc_predictor #(
        .DATA_W (DATA_W),
        .ROT_DIR(ROT_DIR)
    ) u_pred (
        .clk        (clk),
        .rst        (rst),
        .valid      (valid),
        .data       (data),
        .restart    (wr_sel),
        .expect_word(expect_word),
        .armed      (armed)
    );

    assign compare_en = valid && armed;
    assign hit        = compare_en && (data == expect_word);
    assign miss       = compare_en && (data != expect_word);

    always_ff @(posedge clk) begin
        if (rst) begin
            locked_q   <= 1'b0;
            flags.miss <= 1'b0;
            flags.oos  <= 1'b0;
        end else begin
            if (wr_sel)   locked_q <= 1'b0;
            else if (hit) locked_q <= 1'b1;
            flags.miss <= miss | (flags.miss & ~(wr_sel & clr.clr_miss));
            flags.oos  <= (miss & ~locked_q) | (flags.oos & ~(wr_sel & clr.clr_oos));
        end
    end

    // R2: a mismatch is recorded in the following cycle
    assert_miss_sets_flag_R2: assert property (@(posedge clk) disable iff (rst)
        miss |=> flags.miss);

    // R4: a mismatch before lock marks the lane out of sync
    assert_unlocked_miss_oos_R4: assert property (@(posedge clk) disable iff (rst)
        (miss && !locked_q) |=> flags.oos);

    // R3: a seeding word never raises the mismatch flag
    assert_seed_not_flagged_R3: assert property (@(posedge clk) disable iff (rst)
        (valid && !armed && !flags.miss) |=> !flags.miss);

    // R5: a clear with no competing set takes effect
    assert_clear_works_R5: assert property (@(posedge clk) disable iff (rst)
        (wr_sel && clr.clr_miss && !miss) |=> !flags.miss);

    // R5: set flags persist when not cleared
    assert_sticky_R5: assert property (@(posedge clk) disable iff (rst)
        (flags.miss && !(wr_sel && clr.clr_miss)) |=> flags.miss);

    // R6: set beats clear in the same cycle
    assert_set_wins_R6: assert property (@(posedge clk) disable iff (rst)
        (wr_sel && clr.clr_miss && miss) |=> flags.miss);

    // R9: an idle cycle with no write leaves the flags alone
    assert_idle_flags_R9: assert property (@(posedge clk) disable iff (rst)
        (!valid && !wr_sel) |=> $stable(flags));

endmodule

// File: rtl/psc_regfile.sv
module psc_regfile
    import psc_pkg::*;
#(
    parameter int NUM_CH = 2,
    parameter int REG_W  = 8,
    parameter int ADDR_W = 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              reg_wr,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [REG_W-1:0]  reg_wdata,
    input  lane_flags_t       lane_flags [NUM_CH],
    output logic [NUM_CH-1:0] wr_sel,
    output lane_clr_t         clr,
    output logic [REG_W-1:0]  reg_rdata
);

    logic unused_wbits;

    assign clr.clr_miss = reg_wdata[MISS_BIT];
    assign clr.clr_oos  = reg_wdata[OOS_BIT];
    assign unused_wbits = ^{reg_wdata[REG_W-1:OOS_BIT+1], reg_wdata[0]};

    always_comb begin
        wr_sel    = '0;
        reg_rdata = '0;
        for (int i = 0; i < NUM_CH; i++) begin
            if (int'(reg_addr) == i) begin
                wr_sel[i]           = reg_wr;
                reg_rdata[MISS_BIT] = lane_flags[i].miss;
                reg_rdata[OOS_BIT]  = lane_flags[i].oos;
            end
        end
    end

    // R7: a write reaches at most one lane
    assert_one_lane_written_R7: assert property (@(posedge clk) disable iff (rst)
        $onehot0(wr_sel));

    // R8: bits outside the two flags never read as one
    assert_spare_bits_zero_R8: assert property (@(posedge clk) disable iff (rst)
        (reg_rdata[0] == 1'b0) && ((reg_rdata >> (OOS_BIT + 1)) == '0));

endmodule

// File: rtl/shift_pattern_checker.sv
module shift_pattern_checker
    import psc_pkg::*;
#(
    parameter int       NUM_CH  = 2,
    parameter int       DATA_W  = 12,
    parameter int       REG_W   = 8,
    parameter rot_dir_e ROT_DIR = ROT_LEFT,
    localparam int      ADDR_W  = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic [NUM_CH-1:0]        ch_valid,
    input  logic [NUM_CH*DATA_W-1:0] ch_data,
    input  logic                     reg_wr,
    input  logic [ADDR_W-1:0]        reg_addr,
    input  logic [REG_W-1:0]         reg_wdata,
    output logic [REG_W-1:0]         reg_rdata
);

    lane_flags_t       lane_flags [NUM_CH];
    logic [NUM_CH-1:0] wr_sel;
    lane_clr_t         clr;

    psc_regfile #(
        .NUM_CH(NUM_CH),
        .REG_W (REG_W),
        .ADDR_W(ADDR_W)
    ) u_regs (
        .clk       (clk),
        .rst       (rst),
        .reg_wr    (reg_wr),
        .reg_addr  (reg_addr),
        .reg_wdata (reg_wdata),
        .lane_flags(lane_flags),
        .wr_sel    (wr_sel),
        .clr       (clr),
        .reg_rdata (reg_rdata)
    );

    generate
        for (genvar g = 0; g < NUM_CH; g++) begin : g_lane
            psc_lane #(
                .DATA_W (DATA_W),
                .ROT_DIR(ROT_DIR)
            ) u_lane (
                .clk   (clk),
                .rst   (rst),
                .valid (ch_valid[g]),
                .data  (ch_data[g*DATA_W +: DATA_W]),
                .wr_sel(wr_sel[g]),
                .clr   (clr),
                .flags (lane_flags[g])
            );
        end
    endgenerate

endmodule

// File: tb/tb_shift_pattern_checker.sv
module tb_shift_pattern_checker;

    localparam int NUM_CH = 2;
    localparam int DW     = 12;
    localparam int RW     = 8;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic [NUM_CH-1:0] ch_valid = '0;
    logic [NUM_CH*DW-1:0] ch_data = '0;
    logic              reg_wr = 1'b0;
    logic [0:0]        reg_addr = '0;
    logic [RW-1:0]     reg_wdata = '0;
    logic [RW-1:0]     reg_rdata;

    int checks = 0;
    int errors = 0;
    logic [DW-1:0] p0, p1;

    shift_pattern_checker dut (
        .clk(clk), .rst(rst), .ch_valid(ch_valid), .ch_data(ch_data),
        .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata)
    );

    always #2.5 clk = ~clk;

    function automatic logic [DW-1:0] rotl(input logic [DW-1:0] x);
        return {x[DW-2:0], x[DW-1]};
    endfunction

    task automatic chk(input string tag, input logic [RW-1:0] act, input logic [RW-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic read_expect(input int ch, input logic [RW-1:0] exp, input string tag);
        reg_addr = ch[0:0];
        #1;
        chk(tag, reg_rdata, exp);
    endtask

    task automatic push(input int ch, input logic [DW-1:0] d);
        ch_valid[ch] = 1'b1;
        ch_data[ch*DW +: DW] = d;
        @(negedge clk);
        ch_valid = '0;
    endtask

    task automatic write_reg(input int ch, input logic [RW-1:0] v);
        reg_wr = 1'b1; reg_addr = ch[0:0]; reg_wdata = v;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic t_reset;
        read_expect(0, 8'h00, "R8 ch0 after reset");
        read_expect(1, 8'h00, "R8 ch1 after reset");
    endtask

    task automatic t_good_stream;
        p0 = 12'h001;
        push(0, p0);
        for (int i = 0; i < 13; i++) begin
            p0 = rotl(p0);
            push(0, p0);
        end
        read_expect(0, 8'h00, "R1 rotating stream with wrap");
    endtask

    task automatic t_seed_only;
        p1 = 12'hABC;
        push(1, p1);
        read_expect(1, 8'h00, "R3 first word seeds only");
    endtask

    task automatic t_unlocked_miss;
        ch_valid[1] = 1'b1;
        ch_data[DW +: DW] = 12'h000;
        reg_addr = 1'b1;
        #1;
        chk("R2 no flag in arrival cycle", reg_rdata, 8'h00);
        @(negedge clk);
        ch_valid = '0;
        p1 = 12'h000;
        read_expect(1, 8'h06, "R4 R2 miss before lock reads 6");
        read_expect(0, 8'h00, "R7 other channel untouched");
    endtask

    task automatic t_clear_paths;
        write_reg(1, 8'h02);
        read_expect(1, 8'h04, "R5 partial clear keeps oos");
        push(1, 12'h000);
        push(1, 12'h000);
        read_expect(1, 8'h04, "R5 oos sticky without clear");
        write_reg(1, 8'h04);
        read_expect(1, 8'h00, "R5 oos cleared");
        p1 = 12'h010;
        push(1, p1);
        p1 = rotl(p1);
        push(1, p1);
        push(1, 12'h000);
        read_expect(1, 8'h02, "R4 miss after lock reads 2");
        push(1, 12'h000);
        read_expect(1, 8'h02, "R5 mismatch flag sticky");
        write_reg(1, 8'h02);
        read_expect(1, 8'h00, "R5 write-back clears");
        push(1, 12'h001);
        push(1, 12'h003);
        read_expect(1, 8'h06, "R4 fresh lane miss reads 6");
        write_reg(1, 8'h06);
        read_expect(1, 8'h00, "R5 write-back of 6 clears");
        read_expect(0, 8'h00, "R7 ch0 unaffected by ch1 writes");
    endtask

    task automatic t_idle_ignored;
        ch_valid = '0;
        ch_data[0 +: DW] = 12'hFFF;
        repeat (3) @(negedge clk);
        read_expect(0, 8'h00, "R9 idle garbage no flag");
        p0 = rotl(p0);
        push(0, p0);
        read_expect(0, 8'h00, "R9 predictor kept across idle");
    endtask

    task automatic t_set_wins;
        ch_valid[0] = 1'b1;
        ch_data[0 +: DW] = 12'h123;
        reg_wr = 1'b1; reg_addr = 1'b0; reg_wdata = 8'h02;
        @(negedge clk);
        ch_valid = '0; reg_wr = 1'b0;
        read_expect(0, 8'h02, "R6 set wins over clear");
    endtask

    task automatic t_reseed_after_write;
        write_reg(0, 8'h02);
        read_expect(0, 8'h00, "R5 clear ch0");
        p0 = 12'h5A5;
        push(0, p0);
        read_expect(0, 8'h00, "R3 word after write seeds");
        p0 = rotl(p0);
        push(0, p0);
        p0 = rotl(p0);
        push(0, p0);
        read_expect(0, 8'h00, "R1 stream from new seed");
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_good_stream();
        t_seed_only();
        t_unlocked_miss();
        t_clear_paths();
        t_idle_ignored();
        t_set_wins();
        t_reseed_after_write();
        repeat (2) @(negedge clk);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule